// File: doc/BRIEF.md
# Raw NAND Flash Bus Controller

This block connects a simple 32-bit register port to the pins of a raw NAND flash device. Software builds each flash operation by hand. It sets the command-latch, address-latch and chip-enable levels as static bits in a mode register. It then writes bytes to, or reads bytes from, a data register. Each data-register access becomes one strobed bus cycle on the flash pins. The active-low write or read strobe is held for a programmable number of clocks, and the data is then held for a programmable number of clocks after the strobe rises.

Up to four devices share the bus. A two-bit select field picks which one sees an active chip enable. The data path is 8 bits wide by default, and a mode bit widens it to 16 bits. The device ready/busy pin is synchronised and shown in a status register. A soft reset register restores the programmable state over a short, fixed number of clocks. While a flash cycle runs, the register port stalls by holding its ready low, so only one flash cycle is ever in progress.

The register port uses word addresses in `bus_addr[4:2]`:

| Index | Register |
|---|---|
| 0 | data |
| 1 | mode |
| 2 | status |
| 3 | interrupt status |
| 4 | interrupt mask |
| 5 | strobe timing |
| 6 | soft reset |

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset, all chip enables are high, the command-latch and address-latch lines are low, both strobes are high and the data bus is not driven. The mode register reads 0 and the timing register reads 0xFF.
- R2: In the mode register, bit 0 drives the command-latch line and bit 1 drives the address-latch line. When bit 4 is 1, the chip-enable output selected by bits 3:2 is driven low and all others stay high, so at most one chip enable is ever low. Only bits 0-4, 7 and 10 are stored, and the rest read 0.
- R3: A data-register write while mode bit 0 or bit 1 is 1 produces one write strobe whose bus value is the low byte of the write data with bits 15:8 zero. This happens whatever the value of mode bit 7.
- R4: A data-register write while mode bits 0, 1 and 7 are all 0 is ignored. It completes in the cycle it is presented, and no strobe occurs and the data bus is not driven.
- R5: A data-register write with mode bit 7 set produces a write strobe. The bus carries bits 15:0 of the write data when mode bit 10 is 1, and only bits 7:0 (upper byte zero) when it is 0.
- R6: A write strobe is low for SPW+1 clocks, where SPW is timing bits 3:0. The data bus is then still driven for HOLD+2 clocks, where HOLD is timing bits 7:4. `bus_ready` is high in the last hold clock and the bus is released on the next clock.
- R7: A data-register read drives the read strobe low for SPW+1 clocks and samples the bus at the clock edge that ends the strobe. After HOLD+2 further clocks, it returns that value with `bus_ready`. The value is 16 bits when mode bit 10 is 1 and the low byte otherwise.
- R8: Status bit 7 reads 1 when the ready/busy pin is low (device busy), two clocks after the pin changes. Status bit 6, the transfer-running flag, reads 0.
- R9: Writing 1 to reset bit 0 makes that bit read 1 for 4 clocks starting in the clock after the write. It then reads 0. At that point the mode register and interrupt mask are 0 and the timing register is 0xFF.
- R10: Any access to a register other than data completes with `bus_ready` in the same clock it is presented while no flash cycle runs. `bus_ready` is never high without `bus_req`.
- R11: The interrupt status register reads 0. The interrupt mask register stores and returns bits 7:0 of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completes in this clock |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce_n | output | 4 | Active-low chip enables, one per device |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_dq_out | output | 16 | Data driven to the flash |
| fl_dq_oe | output | 1 | Output enable for `fl_dq_out` |
| fl_dq_in | input | 16 | Data from the flash |
| fl_rb_n | input | 1 | Ready/busy pin, low while busy |

## Verification
A wrong sequencer state or counter shows on the strobe pins within one clock. A strobe that is one clock too long or short, or data that is released early, differs from the reference model in the first cycle it goes wrong. A corrupted mode register shows at once on the latch and chip-enable pins, which are compared on every clock. A read captured at the wrong edge is caught because the bench changes the flash data just after the sampling edge. An error in the reset counter shows as a wrong reset-bit read, or as a wrong mode or timing read, in the exact clock where the defaults are due.

// File: rtl/nbc_pkg.sv
`timescale 1ns/1ps
package nbc_pkg;
    localparam int BUS_W      = 32;
    localparam int MODE_W     = 11;
    localparam logic [MODE_W-1:0] MODE_WMASK = 11'h49F;
    localparam int MB_CLE     = 0;
    localparam int MB_ALE     = 1;
    localparam int MB_SEL_LO  = 2;
    localparam int MB_CE      = 4;
    localparam int MB_WEN     = 7;
    localparam int MB_X16     = 10;
    localparam int ST_BUSY    = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STROBE = 2'd1,
        SEQ_HOLD   = 2'd2
    } seq_state_e;

    localparam logic [2:0] RI_DATA  = 3'd0;
    localparam logic [2:0] RI_MODE  = 3'd1;
    localparam logic [2:0] RI_STAT  = 3'd2;
    localparam logic [2:0] RI_ISTAT = 3'd3;
    localparam logic [2:0] RI_IMASK = 3'd4;
    localparam logic [2:0] RI_TIME  = 3'd5;
    localparam logic [2:0] RI_RST   = 3'd6;
endpackage

// File: rtl/nbc_sync.sv
`timescale 1ns/1ps
module nbc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/nbc_strobe_seq.sv
`timescale 1ns/1ps
module nbc_strobe_seq
    import nbc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int DQ_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rd,
    input  logic [CNT_W-1:0] spw,
    input  logic [CNT_W-1:0] hold,
    input  logic [DQ_W-1:0]  wr_data,
    input  logic             x16,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             busy,
    output logic             done,
    output logic             we_n,
    output logic             re_n,
    output logic             dq_oe,
    output logic [DQ_W-1:0]  dq_out,
    output logic [DQ_W-1:0]  rd_data
);
    localparam int TW = CNT_W + 1;
    localparam logic [DQ_W-1:0] LO_MASK = DQ_W'(8'hFF);

    typedef struct packed {
        seq_state_e      state;
        logic [TW-1:0]   cnt;
        logic            is_rd;
        logic [DQ_W-1:0] wdat;
        logic [DQ_W-1:0] rdat;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.state = SEQ_STROBE;
                    s_d.cnt   = TW'(spw);
                    s_d.is_rd = start_rd;
                    s_d.wdat  = wr_data;
                end
            end
            SEQ_STROBE: begin
                if (s_q.cnt == '0) begin
                    s_d.state = SEQ_HOLD;
                    s_d.cnt   = TW'(hold) + TW'(2'd1);
                    if (s_q.is_rd) s_d.rdat = x16 ? dq_in : (dq_in & LO_MASK);
                end else begin
                    s_d.cnt = s_q.cnt - TW'(1'b1);
                end
            end
            SEQ_HOLD: begin
                if (s_q.cnt == '0) s_d.state = SEQ_IDLE;
                else               s_d.cnt   = s_q.cnt - TW'(1'b1);
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= SEQ_IDLE;
            s_q.cnt   <= '0;
            s_q.is_rd <= 1'b0;
            s_q.wdat  <= '0;
            s_q.rdat  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.state != SEQ_IDLE);
    assign done    = (s_q.state == SEQ_HOLD) && (s_q.cnt == '0);
    assign we_n    = !((s_q.state == SEQ_STROBE) && !s_q.is_rd);
    assign re_n    = !((s_q.state == SEQ_STROBE) && s_q.is_rd);
    assign dq_oe   = busy && !s_q.is_rd;
    assign dq_out  = s_q.wdat;
    assign rd_data = s_q.rdat;

    // R6
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> dq_oe);
    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R10
    end_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
endmodule

// File: rtl/nbc_ce_decode.sv
`timescale 1ns/1ps
module nbc_ce_decode #(
    parameter int NUM_CS = 4,
    localparam int SEL_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_en,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CS-1:0] ce_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
        assign ce_n[i] = !(ce_en && (sel == SEL_W'(i)));
    end

    // R2
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));
endmodule

// File: rtl/nand_bus_ctrl.sv
`timescale 1ns/1ps
module nand_bus_ctrl
    import nbc_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int NUM_CS      = 4,
    parameter int CNT_W       = 4,
    parameter int DQ_W        = 16,
    parameter int IMASK_W     = 8,
    parameter int RST_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic [NUM_CS-1:0] fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_re_n,
    output logic [DQ_W-1:0]   fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DQ_W-1:0]   fl_dq_in,
    input  logic              fl_rb_n
);
    localparam int TMG_W = 2 * CNT_W;
    localparam int RST_W = $clog2(RST_CYCLES + 1);
    localparam int SEL_W = $clog2(NUM_CS);
    localparam logic [TMG_W-1:0] TMG_RESET = {TMG_W{1'b1}};
    localparam logic [DQ_W-1:0]  LO_MASK   = DQ_W'(8'hFF);

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [TMG_W-1:0]   tmg;
        logic [IMASK_W-1:0] imask;
        logic [RST_W-1:0]   rcnt;
    } regs_t;

    regs_t r_d, r_q;

    logic              seq_busy, seq_done, seq_start;
    logic [DQ_W-1:0]   seq_wdata, seq_rdata;
    logic              rb_sync, rst_busy;
    logic [2:0]        ridx;
    logic              is_data, wr_strobes, reg_ack;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};

    assign ridx       = bus_addr[4:2];
    assign is_data    = (ridx == RI_DATA);
    assign rst_busy   = (r_q.rcnt != '0);
    assign wr_strobes = r_q.mode[MB_CLE] | r_q.mode[MB_ALE] | r_q.mode[MB_WEN];

    assign seq_start = bus_req && is_data && !seq_busy && !rst_busy &&
                       (!bus_we || wr_strobes);
    assign reg_ack   = bus_req && !seq_busy &&
                       (!is_data || (bus_we && !wr_strobes && !rst_busy));
    assign bus_ready = reg_ack || seq_done;

    always_comb begin
        if (r_q.mode[MB_CLE] || r_q.mode[MB_ALE]) seq_wdata = bus_wdata[DQ_W-1:0] & LO_MASK;
        else if (r_q.mode[MB_X16])                seq_wdata = bus_wdata[DQ_W-1:0];
        else                                      seq_wdata = bus_wdata[DQ_W-1:0] & LO_MASK;
    end

    always_comb begin
        r_d = r_q;
        if (reg_ack && bus_we) begin
            case (ridx)
                RI_MODE:  r_d.mode  = bus_wdata[MODE_W-1:0] & MODE_WMASK;
                RI_TIME:  r_d.tmg   = bus_wdata[TMG_W-1:0];
                RI_IMASK: r_d.imask = bus_wdata[IMASK_W-1:0];
                RI_RST:   if (bus_wdata[0] && !rst_busy) r_d.rcnt = RST_W'(RST_CYCLES);
                default:  ;
            endcase
        end
        if (rst_busy) begin
            r_d.rcnt = r_q.rcnt - RST_W'(1'b1);
            if (r_q.rcnt == RST_W'(1'b1)) begin
                r_d.mode  = '0;
                r_d.tmg   = TMG_RESET;
                r_d.imask = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode  <= '0;
            r_q.tmg   <= TMG_RESET;
            r_q.imask <= '0;
            r_q.rcnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (ridx)
            RI_DATA:  bus_rdata = BUS_W'(seq_rdata);
            RI_MODE:  bus_rdata = BUS_W'(r_q.mode);
            RI_STAT:  bus_rdata[ST_BUSY] = !rb_sync;
            RI_ISTAT: bus_rdata = '0;
            RI_IMASK: bus_rdata = BUS_W'(r_q.imask);
            RI_TIME:  bus_rdata = BUS_W'(r_q.tmg);
            RI_RST:   bus_rdata[0] = rst_busy;
            default:  bus_rdata = '0;
        endcase
    end

    nbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (fl_rb_n),
        .dout (rb_sync)
    );

    nbc_strobe_seq #(.CNT_W(CNT_W), .DQ_W(DQ_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (seq_start),
        .start_rd(!bus_we),
        .spw     (r_q.tmg[CNT_W-1:0]),
        .hold    (r_q.tmg[TMG_W-1:CNT_W]),
        .wr_data (seq_wdata),
        .x16     (r_q.mode[MB_X16]),
        .dq_in   (fl_dq_in),
        .busy    (seq_busy),
        .done    (seq_done),
        .we_n    (fl_we_n),
        .re_n    (fl_re_n),
        .dq_oe   (fl_dq_oe),
        .dq_out  (fl_dq_out),
        .rd_data (seq_rdata)
    );

    nbc_ce_decode #(.NUM_CS(NUM_CS)) u_ce (
        .clk  (clk),
        .rst_n(rst_n),
        .ce_en(r_q.mode[MB_CE]),
        .sel  (r_q.mode[MB_SEL_LO +: SEL_W]),
        .ce_n (fl_ce_n)
    );

    assign fl_cle = r_q.mode[MB_CLE];
    assign fl_ale = r_q.mode[MB_ALE];

    // R9
    rst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_busy) |-> (r_q.mode == '0 && r_q.tmg == TMG_RESET && r_q.imask == '0));
    // R10
    ready_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> bus_req);
    // R10
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && $past(seq_busy)) |-> $stable(r_q.mode));
endmodule

// File: tb/nand_bus_ctrl_tb.sv
`timescale 1ns/1ps
module nand_bus_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ready;
    logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, fl_rb_n;
    logic [3:0]  fl_ce_n;
    logic [15:0] fl_dq_out, fl_dq_in;

    always #2.5 clk = ~clk;

    nand_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .fl_cle(fl_cle), .fl_ale(fl_ale),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_rb_n(fl_rb_n)
    );

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    logic [10:0] m_mode = '0;
    logic [3:0]  m_spw  = 4'hF;
    logic [3:0]  m_hold = 4'hF;
    logic        m_we_n = 1'b1;
    logic        m_re_n = 1'b1;
    logic        m_oe   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_ce(input logic [10:0] md);
        logic [3:0] v;
        v = 4'hF;
        if (md[4]) v[md[3:2]] = 1'b0;
        return v;
    endfunction

    // per-clock reference comparison of every pin
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 cle", 32'(fl_cle), 32'(m_mode[0]));
            chk("R2 ale", 32'(fl_ale), 32'(m_mode[1]));
            chk("R2 ce_n", 32'(fl_ce_n), 32'(exp_ce(m_mode)));
            chk("R6 we_n", 32'(fl_we_n), 32'(m_we_n));
            chk("R7 re_n", 32'(fl_re_n), 32'(m_re_n));
            chk("R6 dq_oe", 32'(fl_dq_oe), 32'(m_oe));
        end
    end

    task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = {idx, 2'b00}; bus_wdata = d;
        @(negedge clk);
        chk("R10 register write ready", 32'(bus_ready), 32'd1);
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
        if (idx == 3'd1) m_mode = d[10:0] & 11'h49F;
        if (idx == 3'd5) {m_hold, m_spw} = d[7:0];
    endtask

    task automatic reg_rd(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = {idx, 2'b00};
        @(negedge clk);
        chk("R10 register read ready", 32'(bus_ready), 32'd1);
        chk(tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic flash_wr(input logic [31:0] d, input bit strobe,
                            input logic [15:0] exp_dq, input string tag);
        int total;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 5'd0; bus_wdata = d;
        if (!strobe) begin
            @(negedge clk);
            chk({tag, " ready"}, 32'(bus_ready), 32'd1);
            @(posedge clk); #1;
            bus_req = 1'b0;
        end else begin
            total = int'(m_spw) + int'(m_hold) + 3;
            for (int i = 0; i <= total; i++) begin
                m_we_n = !(i >= 1 && i <= int'(m_spw) + 1);
                m_oe   = (i >= 1);
                @(negedge clk);
                chk({tag, " ready"}, 32'(bus_ready), 32'(i == total));
                if (i >= 1) chk({tag, " dq"}, 32'(fl_dq_out), 32'(exp_dq));
                @(posedge clk); #1;
            end
            bus_req = 1'b0; m_we_n = 1'b1; m_oe = 1'b0;
        end
    endtask

    task automatic flash_rd(input logic [15:0] val, input logic [31:0] exp, input string tag);
        int total;
        total = int'(m_spw) + int'(m_hold) + 3;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 5'd0; fl_dq_in = val;
        for (int i = 0; i <= total; i++) begin
            m_re_n = !(i >= 1 && i <= int'(m_spw) + 1);
            @(negedge clk);
            chk({tag, " ready"}, 32'(bus_ready), 32'(i == total));
            if (i == total) chk({tag, " data"}, bus_rdata, exp);
            @(posedge clk); #1;
            if (i == int'(m_spw) + 1) fl_dq_in = ~val;
        end
        bus_req = 1'b0; m_re_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) act=hung exp=finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        fl_dq_in = '0; fl_rb_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the pins
        chk("R1 ce_n", 32'(fl_ce_n), 32'hF);
        chk("R1 strobes", 32'({fl_we_n, fl_re_n, fl_dq_oe}), 32'b110);
        @(posedge clk); #1;
        reg_rd(3'd1, 32'h0,  "R1 mode after reset");
        reg_rd(3'd5, 32'hFF, "R1 timing after reset");

        // R6 short timing: hold=2, spw=1
        reg_wr(3'd5, 32'h21);
        // R2 mode bits and masking
        reg_wr(3'd1, 32'hFFFF_FB60);
        reg_rd(3'd1, 32'h0000_0000, "R2 unstored mode bits");
        reg_wr(3'd1, 32'h19);
        reg_rd(3'd1, 32'h19, "R2 mode readback");
        // R3 command cycle carries only the low byte
        flash_wr(32'h1234_5690, 1'b1, 16'h0090, "R3 command write");
        reg_wr(3'd1, 32'h41A);
        flash_wr(32'h0000_77AB, 1'b1, 16'h00AB, "R3 address write x16 set");
        // R4 ignored write
        reg_wr(3'd1, 32'h18);
        flash_wr(32'h0000_5555, 1'b0, 16'h0, "R4 ignored data write");
        idle(2);
        // R5 data writes, 8 and 16 bit
        reg_wr(3'd1, 32'h94);
        flash_wr(32'h0000_BEEF, 1'b1, 16'h00EF, "R5 x8 data write");
        reg_wr(3'd5, 32'h53);
        reg_wr(3'd1, 32'h49C);
        flash_wr(32'hAAAA_BEEF, 1'b1, 16'hBEEF, "R6 R5 x16 data write long timing");
        // R7 reads
        flash_rd(16'hC3A5, 32'h0000_C3A5, "R7 x16 read");
        reg_wr(3'd1, 32'h010);
        reg_wr(3'd5, 32'h10);
        flash_rd(16'h5A3C, 32'h0000_003C, "R7 x8 read min timing");
        // R8 ready/busy
        fl_rb_n = 1'b0;
        idle(3);
        reg_rd(3'd2, 32'h80, "R8 busy status");
        fl_rb_n = 1'b1;
        idle(3);
        reg_rd(3'd2, 32'h00, "R8 ready status");
        // R11 interrupt registers
        reg_rd(3'd3, 32'h0, "R11 interrupt status");
        reg_wr(3'd4, 32'h1234_56A5);
        reg_rd(3'd4, 32'hA5, "R11 interrupt mask");
        // R9 soft reset
        reg_wr(3'd1, 32'h1B);
        reg_wr(3'd5, 32'h53);
        reg_wr(3'd6, 32'h1);
        for (int k = 0; k < 4; k++) reg_rd(3'd6, 32'h1, "R9 reset bit pending");
        m_mode = '0; m_spw = 4'hF; m_hold = 4'hF;
        reg_rd(3'd6, 32'h0, "R9 reset bit cleared");
        reg_rd(3'd1, 32'h0,  "R9 mode defaults");
        reg_rd(3'd5, 32'hFF, "R9 timing defaults");
        reg_rd(3'd4, 32'h0,  "R9 mask defaults");
        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule